// File: doc/BRIEF.md
# Serial ADC Frame Sequencer

This block is the host side of a link to a 10-bit serial analog-to-digital converter. Each accepted start request runs one frame. The block drops chip select, raises a frame-sync marker and generates a free-standing I/O clock from the system clock. On that clock it sends a 4-bit command to the converter and collects the 10-bit result of the conversion that the previous command started. The command picks the input channel, the power-down setting and the conversion speed. The block forwards it without decoding it.

The converter starts converting partway through the frame and pulls its end-of-conversion line low while it works. After the frame the sequencer waits for that line to go low and then return high. When it does, the block publishes the collected word, pulses a valid strobe and raises an interrupt. Start requests that arrive while a frame or a conversion is in progress have no effect.

Top module: `adc_frame_ctrl`

## Requirements
- R1: The command captured when a start is accepted is sent on `adc_din` MSB first. Bit 3 is launched on I/O clock rising edge 1 and bit 0 on rising edge 4. `adc_din` changes only at an I/O clock rising edge.
- R2: `adc_dout` is sampled on I/O clock falling edges 1 to 10, and the first sample is result bit 9. The assembled word appears on `result` in the cycle `result_valid` is high.
- R3: `fs` is high from the cycle a start is accepted until I/O clock falling edge 1. `cs_n` is low from acceptance until falling edge 16, and `fs` is never high while `cs_n` is high.
- R4: A frame has exactly 16 I/O clock periods. `io_clk` is low whenever `cs_n` is high.
- R5: The I/O clock period is `DIV` system clocks with equal high and low halves. A `DIV` that is odd, below 2 or gives more than `MAX_IO_HZ` is rejected at elaboration.
- R6: After a frame the block waits for `adc_eoc` to be low and then high. `result_valid` goes high for exactly one cycle, starting the cycle after `adc_eoc` is first seen high.
- R7: `irq` rises together with `result_valid` and stays high until the next start is accepted. It is low in the cycle after that acceptance.
- R8: A start request is ignored from acceptance until the `result_valid` pulse: no extra frame runs and the command sent is unchanged.
- R9: During and after reset `cs_n` is high and `fs`, `io_clk`, `adc_din`, `result_valid`, `irq` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one frame |
| cmd | input | 4 | Command nibble, captured when a start is accepted |
| adc_dout | input | 1 | Serial result bit from the converter |
| adc_eoc | input | 1 | End of conversion, low while converting |
| cs_n | output | 1 | Converter chip select, active low |
| fs | output | 1 | Frame-sync marker |
| adc_din | output | 1 | Serial command bit to the converter |
| io_clk | output | 1 | Generated I/O clock |
| result | output | 10 | Last collected conversion word |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
Several rules are checked by the assertions on every cycle. Frame sync appears only inside a frame and the I/O clock is quiet while chip select is high. The command line changes only on I/O clock rising edges. The valid strobe lasts one cycle, follows a low-to-high end-of-conversion transition and never occurs without the interrupt. The bench scenarios show what the assertions cannot: the bit order in both directions, the count of 16 periods, the measured period and duty cycle, the pairing of each result with the previous frame, and that starts issued mid-frame are dropped.

// File: rtl/adcfs_pkg.sv
package adcfs_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_SHIFT = 2'd1,
      SEQ_CONV_LO = 2'd2,
      SEQ_CONV_HI = 2'd3
   } seq_state_t;

   function automatic bit div_ok(input int div, input longint sys_hz, input longint max_hz);
      return (div >= 2) && (div % 2 == 0) && (sys_hz <= max_hz * longint'(div));
   endfunction

endpackage

// File: rtl/adcfs_ioclk_gen.sv
module adcfs_ioclk_gen #(
   parameter int DIV     = 26,
   parameter int PERIODS = 16,
   parameter int PW      = $clog2(PERIODS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic          io_clk,
   output logic          rise,
   output logic          fall,
   output logic [PW-1:0] per_idx,
   output logic          last_fall
);
   localparam int HALF = DIV / 2;
   localparam int CW   = PW + 1;

   logic          tick;
   logic [CW-1:0] halves;

   generate
      if (HALF == 1) begin : g_fast
         assign tick = run;
      end else begin : g_count
         localparam int HCW = $clog2(HALF);
         logic [HCW-1:0] hcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hcnt <= '0;
            end else if (!run || hcnt == HCW'(HALF - 1)) begin
               hcnt <= '0;
            end else begin
               hcnt <= hcnt + 1'b1;
            end
         end
         assign tick = run && (hcnt == HCW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halves <= '0;
         io_clk <= 1'b0;
      end else if (!run) begin
         halves <= '0;
         io_clk <= 1'b0;
      end else if (tick) begin
         halves <= halves + 1'b1;
         io_clk <= ~io_clk;
      end
   end

   assign per_idx   = halves[CW-1:1];
   assign rise      = tick && !halves[0];
   assign fall      = tick && halves[0];
   assign last_fall = fall && (per_idx == PW'(PERIODS - 1));

endmodule

// File: rtl/adcfs_shifter.sv
module adcfs_shifter #(
   parameter int CMD_W = 4,
   parameter int RES_W = 10,
   parameter int PW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CMD_W-1:0] cmd_in,
   input  logic             rise,
   input  logic             fall,
   input  logic [PW-1:0]    per_idx,
   input  logic             sdi,
   output logic             sdo,
   output logic [RES_W-1:0] cap_word
);
   logic [CMD_W-1:0] cmd_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_sr <= '0;
         sdo    <= 1'b0;
      end else if (load) begin
         cmd_sr <= cmd_in;
      end else if (rise) begin
         if (int'(per_idx) < CMD_W) begin
            sdo    <= cmd_sr[CMD_W-1];
            cmd_sr <= {cmd_sr[CMD_W-2:0], 1'b0};
         end else begin
            sdo <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_word <= '0;
      end else if (load) begin
         cap_word <= '0;
      end else if (fall && int'(per_idx) < RES_W) begin
         cap_word <= {cap_word[RES_W-2:0], sdi};
      end
   end

endmodule

// File: rtl/adcfs_sequencer.sv
module adcfs_sequencer
   import adcfs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic fall,
   input  logic last_fall,
   input  logic eoc,
   output logic run,
   output logic load,
   output logic commit,
   output logic cs_n,
   output logic fs,
   output logic valid,
   output logic irq
);
   seq_state_t state;

   assign run    = (state == SEQ_SHIFT);
   assign load   = (state == SEQ_IDLE) && start;
   assign commit = (state == SEQ_CONV_HI) && eoc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cs_n  <= 1'b1;
         fs    <= 1'b0;
         valid <= 1'b0;
         irq   <= 1'b0;
      end else begin
         valid <= commit;
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state <= SEQ_SHIFT;
                  cs_n  <= 1'b0;
                  fs    <= 1'b1;
                  irq   <= 1'b0;
               end
            end
            SEQ_SHIFT: begin
               if (fall) begin
                  fs <= 1'b0;
               end
               if (last_fall) begin
                  state <= SEQ_CONV_LO;
                  cs_n  <= 1'b1;
               end
            end
            SEQ_CONV_LO: begin
               if (!eoc) begin
                  state <= SEQ_CONV_HI;
               end
            end
            SEQ_CONV_HI: begin
               if (eoc) begin
                  state <= SEQ_IDLE;
                  irq   <= 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
   parameter int     DIV       = 26,
   parameter longint SYS_HZ    = 200_000_000,
   parameter longint MAX_IO_HZ = 8_000_000,
   parameter int     CMD_W     = 4,
   parameter int     RES_W     = 10,
   parameter int     PERIODS   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CMD_W-1:0] cmd,
   input  logic             adc_dout,
   input  logic             adc_eoc,
   output logic             cs_n,
   output logic             fs,
   output logic             adc_din,
   output logic             io_clk,
   output logic [RES_W-1:0] result,
   output logic             result_valid,
   output logic             irq
);
   localparam int PW = $clog2(PERIODS);

   generate
      if (!adcfs_pkg::div_ok(DIV, SYS_HZ, MAX_IO_HZ)) begin : g_bad_div
         $error("DIV must be even, at least 2, and keep the I/O clock within MAX_IO_HZ");
      end
      if (CMD_W < 2 || RES_W < 2 || CMD_W > PERIODS || RES_W > PERIODS) begin : g_bad_widths
         $error("command and result widths must fit inside one frame");
      end
   endgenerate

   logic          run, load, commit;
   logic          rise, fall, last_fall;
   logic [PW-1:0] per_idx;
   logic [RES_W-1:0] cap_word;

   adcfs_ioclk_gen #(.DIV(DIV), .PERIODS(PERIODS), .PW(PW)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(run), .io_clk(io_clk),
      .rise(rise), .fall(fall), .per_idx(per_idx), .last_fall(last_fall)
   );

   adcfs_shifter #(.CMD_W(CMD_W), .RES_W(RES_W), .PW(PW)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .cmd_in(cmd),
      .rise(rise), .fall(fall), .per_idx(per_idx), .sdi(adc_dout),
      .sdo(adc_din), .cap_word(cap_word)
   );

   adcfs_sequencer u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .fall(fall),
      .last_fall(last_fall), .eoc(adc_eoc), .run(run), .load(load),
      .commit(commit), .cs_n(cs_n), .fs(fs), .valid(result_valid), .irq(irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
      end else if (commit) begin
         result <= cap_word;
      end
   end

endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic fs,
   input logic adc_din,
   input logic io_clk,
   input logic adc_eoc,
   input logic result_valid,
   input logic irq
);
   // R3: frame sync only inside an active frame
   a_r3_fs_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
      fs |-> !cs_n);

   // R4: I/O clock quiet while chip select is inactive
   a_r4_clk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !io_clk);

   // R1: command line moves only with an I/O clock rising edge
   a_r1_din_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(adc_din) |-> $rose(io_clk));

   // R6: strobe is a single cycle
   a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   // R6: strobe follows a low-to-high end-of-conversion transition
   a_r6_valid_after_eoc_rise: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> ($past(adc_eoc) && !$past(adc_eoc, 2)));

   // R7: interrupt raised with the strobe
   a_r7_irq_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> irq);

endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs(fs), .adc_din(adc_din),
   .io_clk(io_clk), .adc_eoc(adc_eoc), .result_valid(result_valid), .irq(irq)
);

// File: tb/adc_frame_ctrl_tb.sv
`timescale 1ns/1ps
module adc_frame_ctrl_tb;
   localparam int DIV = 26;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] cmd = 4'h0;
   logic       adc_dout = 1'b0;
   logic       adc_eoc = 1'b1;
   logic       cs_n, fs, adc_din, io_clk, result_valid, irq;
   logic [9:0] result;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   adc_frame_ctrl #(.DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
      .adc_dout(adc_dout), .adc_eoc(adc_eoc), .cs_n(cs_n), .fs(fs),
      .adc_din(adc_din), .io_clk(io_clk), .result(result),
      .result_valid(result_valid), .irq(irq)
   );

   // converter model
   logic [9:0] adc_word = 10'h2A5;
   logic [9:0] word_sr = '0;
   logic [9:0] exp_word = '0;
   logic [3:0] rx_cmd = '0;
   int   rise_cnt = 0, fall_cnt = 0, frames = 0;
   bit   fs_r1 = 0, fs_r2 = 1, frame_seen = 0;
   time  last_rise = 0, period = 0, hi_len = 0;

   always @(negedge cs_n) begin
      frames++;
      frame_seen = 1;
      rise_cnt = 0;
      fall_cnt = 0;
      exp_word = adc_word;
      word_sr = adc_word;
   end

   always @(posedge io_clk) begin
      if (!cs_n) begin
         rise_cnt++;
         if (rise_cnt == 1) fs_r1 = fs;
         if (rise_cnt == 2) fs_r2 = fs;
         if (rise_cnt > 1) period = $time - last_rise;
         last_rise = $time;
         adc_dout = word_sr[9];
         word_sr = {word_sr[8:0], 1'b0};
      end
   end

   always @(negedge io_clk) begin
      fall_cnt++;
      hi_len = $time - last_rise;
      if (fall_cnt <= 4) rx_cmd = {rx_cmd[2:0], adc_din};
      if (fall_cnt == 10) adc_eoc = 1'b0;
   end

   always @(posedge cs_n) begin
      if (frame_seen) begin
         int wait_c;
         wait_c = 8 + int'($urandom % 40);
         repeat (wait_c) @(negedge clk);
         adc_word = {rx_cmd, 6'($urandom)};
         adc_eoc = 1'b1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_frame(input logic [3:0] c, input bit poke);
      int f0, t;
      f0 = frames;
      @(negedge clk);
      start = 1'b1;
      cmd = c;
      @(negedge clk);
      start = 1'b0;
      cmd = ~c;
      chk(irq == 1'b0, "R7 irq cleared on accept", int'(irq), 0);
      chk(cs_n == 1'b0 && fs == 1'b1, "R3 cs/fs at accept", int'({cs_n, fs}), 1);
      if (poke) begin
         repeat (60 + int'($urandom % 300)) @(negedge clk);
         start = 1'b1;
         cmd = 4'h5 ^ c;
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      while (!result_valid && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(result_valid == 1'b1, "R6 valid seen", int'(result_valid), 1);
      chk(result == exp_word, "R2 result word", int'(result), int'(exp_word));
      chk(irq == 1'b1, "R7 irq with valid", int'(irq), 1);
      chk(rx_cmd == c, "R1 command bits", int'(rx_cmd), int'(c));
      chk(rise_cnt == 16, "R4 periods per frame", rise_cnt, 16);
      chk(period == time'(DIV * 5), "R5 io_clk period", int'(period), DIV * 5);
      chk(hi_len == time'(DIV * 5 / 2), "R5 io_clk high half", int'(hi_len), DIV * 5 / 2);
      chk(fs_r1 == 1'b1 && fs_r2 == 1'b0, "R3 fs window", int'({fs_r1, fs_r2}), 2);
      chk(frames == f0 + 1, "R8 single frame", frames, f0 + 1);
      chk(cs_n == 1'b1 && io_clk == 1'b0, "R4 idle pins", int'({cs_n, io_clk}), 2);
      @(negedge clk);
      chk(result_valid == 1'b0, "R6 valid one cycle", int'(result_valid), 0);
      chk(irq == 1'b1, "R7 irq held", int'(irq), 1);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk(cs_n == 1'b1 && fs == 1'b0 && io_clk == 1'b0 && adc_din == 1'b0,
          "R9 reset pins", int'({cs_n, fs, io_clk, adc_din}), 8);
      chk(result == 10'd0 && result_valid == 1'b0 && irq == 1'b0,
          "R9 reset outputs", int'(result), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      do_frame(4'hF, 1'b0);
      do_frame(4'h0, 1'b0);
      do_frame(4'hA, 1'b1);
      do_frame(4'h5, 1'b1);
      for (int i = 0; i < 30; i++) begin
         repeat (int'($urandom % 20)) @(negedge clk);
         do_frame(4'($urandom), 1'($urandom));
      end
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule